// File: doc/BRIEF.md
# Partitioned Event Counter Bank

This block holds a bank of 64-bit event counters and one 64-bit cycle counter for a performance-monitoring unit in a virtualised processor. A control register owned by the hypervisor sets a split index. Counters below the index form the lower range, which the guest uses. Counters at or above the index form the upper range, which the hypervisor keeps for itself. The two ranges differ in three ways: how a counter is enabled, where it flags overflow, and whether a privilege-level-2 prohibit applies to it.

Each event counter counts single-cycle event pulses. The cycle counter counts a cycle tick. Counting is gated by a per-counter enable, by the current privilege level (0 to 3) and by the control-register fields. Every counter has a sticky overflow flag, which is cleared by a write-one-to-clear pulse vector. A register port lets software write any counter and read any counter. Event selection, interrupts and access trapping are handled elsewhere.

Top module: `pmu_part_bank`

## Requirements
- R1: On reset all counters and overflow flags are 0. The split index resets to NUM_EVT, so every event counter is in the lower range. The lower prohibit, the level-2 cycle disable, the prohibit link, the upper enable and the long-count bit all reset to 0.
- R2: The effective split index is the programmed value when that value lies in 1..NUM_EVT. A programmed value of 0, or a value above NUM_EVT, acts as NUM_EVT.
- R3: A lower-range counter increments by 1 on a cycle with its event pulse, provided that its own enable bit is 1 and it is not prohibited (R5). A counter with no pulse, or with its enable bit at 0, holds its value.
- R4: An upper-range counter increments only when its event pulse, its own enable bit and the upper-range enable bit are all 1.
- R5: With the lower prohibit set and a privilege level of 2, lower-range counters do not count. Upper-range counters are unaffected, and the prohibit has no effect at any other privilege level.
- R6: The cycle counter increments on a tick when its enable is 1. At privilege level 2 it is stopped in two cases: when the level-2 cycle disable is set, or when both the lower prohibit and the prohibit link are set. The level-2 cycle disable has no effect on the event counters.
- R7: A counter always increments across its full 64 bits. Lower-range counters raise their overflow flag when bits [31:0] wrap from all ones. Upper-range counters do the same when the long-count bit is 0, and raise it only on a wrap of all 64 bits when the long-count bit is 1. The cycle counter raises its flag on a 64-bit wrap.
- R8: Overflow flag bit i belongs to event counter i, and bit NUM_EVT belongs to the cycle counter. Flags stay set until a 1 is given in the matching bit of the clear vector. A new overflow in the same cycle as a clear leaves the flag set.
- R9: A register write takes priority over an increment in the same cycle, and the write never raises an overflow flag. Index i selects event counter i, and index NUM_EVT selects the cycle counter. A write to any higher index changes nothing.
- R10: The read data is a combinational function of the read index and shows the selected counter in the same cycle. Indices above NUM_EVT read as 0.
- R11: A control write pulse loads all control fields at the next clock edge. The new fields govern counting from the following cycle on.
- R12: When the effective split equals NUM_EVT, the upper enable and the long-count bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_lvl_i | input | 2 | Current privilege level 0..3 |
| evt_i | input | NUM_EVT | Per-counter event pulses |
| cnt_en_i | input | NUM_EVT | Per-counter enable bits |
| cyc_tick_i | input | 1 | Cycle counter tick |
| cyc_en_i | input | 1 | Cycle counter enable |
| ctl_we_i | input | 1 | Control register write pulse |
| ctl_split_i | input | SPLIT_W | Split index to load |
| ctl_upper_en_i | input | 1 | Upper-range enable to load |
| ctl_long_i | input | 1 | Upper-range 64-bit overflow select to load |
| ctl_prohibit_i | input | 1 | Lower-range level-2 prohibit to load |
| ctl_cyc_dis_i | input | 1 | Cycle counter level-2 disable to load |
| ctl_link_i | input | 1 | Links the prohibit to the cycle counter, to load |
| ovf_clr_i | input | NUM_EVT+1 | Write-one-to-clear overflow pulses |
| wr_en_i | input | 1 | Counter write strobe |
| wr_idx_i | input | IW | Counter write index |
| wr_data_i | input | CNT_W | Counter write data |
| rd_idx_i | input | IW | Counter read index |
| rd_data_o | output | CNT_W | Selected counter value |
| evt_cnt_o | output | NUM_EVT*CNT_W | All event counter values, counter i at bits [i*CNT_W +: CNT_W] |
| cyc_cnt_o | output | CNT_W | Cycle counter value |
| ovf_o | output | NUM_EVT+1 | Sticky overflow flags |

## Verification
Increments, counter writes, flag sets, flag clears and control loads all take effect at the first rising edge after the inputs are driven. Their results are therefore checked one cycle later, on that edge's following falling edge. The read port is combinational, so its value is sampled on the falling edge of the cycle in which the index is presented. The driver puts its stimulus on just after a falling edge. It queues the expected values just after the next rising edge, and the monitor compares them at the falling edge that follows, so every check lands in the cycle its result is due.

// File: rtl/pmu_part_pkg.sv
package pmu_part_pkg;
  typedef struct packed {
    logic upper_en;
    logic long_cnt;
    logic lower_prohibit;
    logic cyc_dis;
    logic cyc_link;
  } pmu_flags_t;

  localparam logic [1:0] PrivHyp = 2'd2;
endpackage

// File: rtl/pmu_split_ctl.sv
module pmu_split_ctl
  import pmu_part_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned SPLIT_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SPLIT_W-1:0] split_i,
  input  pmu_flags_t         flags_i,
  output logic [SPLIT_W-1:0] eff_split_o,
  output pmu_flags_t         flags_o
);
  localparam logic [SPLIT_W-1:0] SplitMax = SPLIT_W'(NUM_EVT);

  logic [SPLIT_W-1:0] split_q;
  pmu_flags_t         flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q <= SplitMax;
      flags_q <= '0;
    end else if (we_i) begin
      split_q <= split_i;
      flags_q <= flags_i;
    end
  end

  // out-of-range split behaves as "all lower"
  always_comb begin
    if (split_q == '0 || split_q > SplitMax) eff_split_o = SplitMax;
    else                                   eff_split_o = split_q;
  end

  assign flags_o = flags_q;

  a_r2_split_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_split_o != '0) && (eff_split_o <= SplitMax));
endmodule

// File: rtl/pmu_gate.sv
module pmu_gate
  import pmu_part_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned SPLIT_W = 5
) (
  input  logic [SPLIT_W-1:0] eff_split_i,
  input  pmu_flags_t         flags_i,
  input  logic [1:0]         priv_lvl_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] cnt_en_i,
  input  logic               cyc_tick_i,
  input  logic               cyc_en_i,
  output logic [NUM_EVT:0]   inc_o,
  output logic [NUM_EVT:0]   wide_o
);
  logic at_hyp;
  assign at_hyp = (priv_lvl_i == PrivHyp);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam logic [SPLIT_W-1:0] Idx = SPLIT_W'(i);
    logic in_upper;
    assign in_upper = (Idx >= eff_split_i);
    always_comb begin
      if (in_upper) begin
        inc_o[i]  = evt_i[i] & cnt_en_i[i] & flags_i.upper_en;
        wide_o[i] = flags_i.long_cnt;
      end else begin
        inc_o[i]  = evt_i[i] & cnt_en_i[i] & ~(at_hyp & flags_i.lower_prohibit);
        wide_o[i] = 1'b0;
      end
    end
  end

  assign inc_o[NUM_EVT]  = cyc_tick_i & cyc_en_i &
                           ~(at_hyp & (flags_i.cyc_dis |
                                       (flags_i.lower_prohibit & flags_i.cyc_link)));
  assign wide_o[NUM_EVT] = 1'b1;
endmodule

// File: rtl/pmu_cnt_cell.sv
module pmu_cnt_cell #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned LOW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wide_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] val_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] val_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = wide_i ? (&val_q) : (&val_q[LOW_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (wr_i)   val_q <= wr_data_i;
    else if (inc_i)  val_q <= val_q + 1'b1;
  end

  // set beats clear; a write suppresses the increment and its overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovf_q <= 1'b0;
    else if (inc_i && !wr_i && wrap)   ovf_q <= 1'b1;
    else if (clr_i)                    ovf_q <= 1'b0;
  end

  assign val_o = val_q;
  assign ovf_o = ovf_q;

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (val_o == $past(wr_data_i)));
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(val_o));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  a_r7_no_spurious_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(inc_i && !wr_i)) |=> !ovf_o);
endmodule

// File: rtl/pmu_part_bank.sv
module pmu_part_bank
  import pmu_part_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned LOW_W   = 32,
  parameter int unsigned SPLIT_W = 5,
  parameter int unsigned IW      = $clog2(NUM_EVT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               priv_lvl_i,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [NUM_EVT-1:0]       cnt_en_i,
  input  logic                     cyc_tick_i,
  input  logic                     cyc_en_i,
  input  logic                     ctl_we_i,
  input  logic [SPLIT_W-1:0]       ctl_split_i,
  input  logic                     ctl_upper_en_i,
  input  logic                     ctl_long_i,
  input  logic                     ctl_prohibit_i,
  input  logic                     ctl_cyc_dis_i,
  input  logic                     ctl_link_i,
  input  logic [NUM_EVT:0]         ovf_clr_i,
  input  logic                     wr_en_i,
  input  logic [IW-1:0]            wr_idx_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  input  logic [IW-1:0]            rd_idx_i,
  output logic [CNT_W-1:0]         rd_data_o,
  output logic [NUM_EVT*CNT_W-1:0] evt_cnt_o,
  output logic [CNT_W-1:0]         cyc_cnt_o,
  output logic [NUM_EVT:0]         ovf_o
);
  localparam int unsigned NumCnt = NUM_EVT + 1;

  logic [SPLIT_W-1:0] eff_split;
  pmu_flags_t         flags_in, flags;
  logic [NUM_EVT:0]   inc, wide, wr_sel;
  logic [CNT_W-1:0]   vals [NumCnt];

  assign flags_in = '{upper_en:       ctl_upper_en_i,
                      long_cnt:       ctl_long_i,
                      lower_prohibit: ctl_prohibit_i,
                      cyc_dis:        ctl_cyc_dis_i,
                      cyc_link:       ctl_link_i};

  pmu_split_ctl #(.NUM_EVT(NUM_EVT), .SPLIT_W(SPLIT_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .split_i     (ctl_split_i),
    .flags_i     (flags_in),
    .eff_split_o (eff_split),
    .flags_o     (flags)
  );

  pmu_gate #(.NUM_EVT(NUM_EVT), .SPLIT_W(SPLIT_W)) u_gate (
    .eff_split_i (eff_split),
    .flags_i     (flags),
    .priv_lvl_i  (priv_lvl_i),
    .evt_i       (evt_i),
    .cnt_en_i    (cnt_en_i),
    .cyc_tick_i  (cyc_tick_i),
    .cyc_en_i    (cyc_en_i),
    .inc_o       (inc),
    .wide_o      (wide)
  );

  for (genvar k = 0; k < NumCnt; k++) begin : g_cnt
    assign wr_sel[k] = wr_en_i && (wr_idx_i == IW'(k));
    pmu_cnt_cell #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc[k]),
      .wide_i    (wide[k]),
      .wr_i      (wr_sel[k]),
      .wr_data_i (wr_data_i),
      .clr_i     (ovf_clr_i[k]),
      .val_o     (vals[k]),
      .ovf_o     (ovf_o[k])
    );
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_out
    assign evt_cnt_o[k*CNT_W +: CNT_W] = vals[k];
  end
  assign cyc_cnt_o = vals[NUM_EVT];

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NumCnt; k++) begin
      if (rd_idx_i == IW'(k)) rd_data_o = vals[k];
    end
  end

  // counter 0 is always in the lower range
  a_r5_lower_prohibited: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_lvl_i == PrivHyp && flags.lower_prohibit && !wr_sel[0]) |=> $stable(vals[0]));
  a_r6_cyc_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_lvl_i == PrivHyp && flags.cyc_dis && !wr_sel[NUM_EVT]) |=> $stable(vals[NUM_EVT]));
  a_r4_upper_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags.upper_en && eff_split <= SPLIT_W'(NUM_EVT - 1) && !wr_sel[NUM_EVT-1])
      |=> $stable(vals[NUM_EVT-1]));
endmodule

// File: tb/sim_pmu_part_bank.sv
`timescale 1ns/1ps
module sim_pmu_part_bank;
  localparam int N  = 4;
  localparam int CW = 64;
  localparam int SW = 5;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv_lvl = '0;
  logic [N-1:0] evt = '0, cnt_en = '0;
  logic tick = 1'b0, cyc_en = 1'b0;
  logic ctl_we = 1'b0;
  logic [SW-1:0] ctl_split = '0;
  logic ctl_upper_en = 1'b0, ctl_long = 1'b0, ctl_prohibit = 1'b0, ctl_cyc_dis = 1'b0, ctl_link = 1'b0;
  logic [N:0] ovf_clr = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data, cyc_cnt;
  logic [N*CW-1:0] evt_cnt;
  logic [N:0] ovf;

  always #2 clk = ~clk;

  pmu_part_bank #(.NUM_EVT(N), .CNT_W(CW), .SPLIT_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .priv_lvl_i(priv_lvl), .evt_i(evt), .cnt_en_i(cnt_en),
    .cyc_tick_i(tick), .cyc_en_i(cyc_en), .ctl_we_i(ctl_we), .ctl_split_i(ctl_split),
    .ctl_upper_en_i(ctl_upper_en), .ctl_long_i(ctl_long), .ctl_prohibit_i(ctl_prohibit),
    .ctl_cyc_dis_i(ctl_cyc_dis), .ctl_link_i(ctl_link), .ovf_clr_i(ovf_clr), .wr_en_i(wr_en),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .evt_cnt_o(evt_cnt), .cyc_cnt_o(cyc_cnt), .ovf_o(ovf));

  typedef struct {
    int          kind;   // 0 counter, 1 overflow vector, 2 read data
    int          idx;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: compare everything queued since the last falling edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] got;
      it = q.pop_front();
      case (it.kind)
        0:       got = (it.idx < N) ? evt_cnt[it.idx*CW +: CW] : cyc_cnt;
        1:       got = 64'(ovf);
        default: got = rd_data;
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: kind %0d idx %0d got %h exp %h", it.req, it.kind, it.idx, got, it.exp);
      end
    end
  end

  task automatic prep();
    @(negedge clk); #1;
  endtask

  task automatic step();
    @(posedge clk); #1;
    evt = '0; tick = 1'b0; ctl_we = 1'b0; ovf_clr = '0; wr_en = 1'b0;
  endtask

  task automatic exp_cnt(int idx, logic [63:0] v, string req);
    q.push_back('{kind: 0, idx: idx, exp: v, req: req});
  endtask

  task automatic exp_ovf(logic [N:0] v, string req);
    q.push_back('{kind: 1, idx: 0, exp: 64'(v), req: req});
  endtask

  task automatic exp_rd(logic [63:0] v, string req);
    q.push_back('{kind: 2, idx: 0, exp: v, req: req});
  endtask

  task automatic exp_evt4(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [63:0] d, string req);
    exp_cnt(0, a, req); exp_cnt(1, b, req); exp_cnt(2, c, req); exp_cnt(3, d, req);
  endtask

  task automatic set_ctl(int split, bit ue, bit lg, bit pr, bit cd, bit lk);
    prep();
    ctl_we = 1'b1; ctl_split = SW'(split); ctl_upper_en = ue; ctl_long = lg;
    ctl_prohibit = pr; ctl_cyc_dis = cd; ctl_link = lk;
    step();
  endtask

  task automatic wr_cnt(int idx, logic [63:0] v);
    prep();
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = v;
    step();
  endtask

  task automatic pulse(logic [N-1:0] e, bit t);
    prep();
    evt = e; tick = t;
    step();
  endtask

  task automatic clear_all(string req);
    prep(); ovf_clr = '1; step();
    exp_ovf('0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    prep(); step();
    exp_evt4(0, 0, 0, 0, "R1"); exp_cnt(N, 0, "R1"); exp_ovf('0, "R1");

    // R1 reset controls: all lower, no prohibit, cycle counts at level 2
    priv_lvl = 2'd2; cnt_en = '1; cyc_en = 1'b1;
    pulse('1, 1'b1);
    exp_evt4(1, 1, 1, 1, "R1"); exp_cnt(N, 1, "R1");

    // R11 split load, R4 upper off
    set_ctl(2, 0, 0, 0, 0, 0);
    pulse('1, 1'b0);
    exp_evt4(2, 2, 1, 1, "R4");

    // R4 upper needs both enables
    set_ctl(2, 1, 0, 0, 0, 0);
    cnt_en = 4'b0111;
    pulse('1, 1'b0);
    exp_evt4(3, 3, 2, 1, "R4");

    // R3 own enable and pulse
    cnt_en = 4'b0101;
    pulse(4'b0011, 1'b0);
    exp_evt4(4, 3, 2, 1, "R3");
    cnt_en = '1;

    // R5 prohibit at level 2 only, upper unaffected; R6 unlinked cycle counts
    set_ctl(2, 1, 0, 1, 0, 0);
    pulse('1, 1'b1);
    exp_evt4(4, 3, 3, 2, "R5"); exp_cnt(N, 2, "R6");
    priv_lvl = 2'd1;
    pulse('1, 1'b0);
    exp_evt4(5, 4, 4, 3, "R5");

    // R6 link stops cycle at level 2, not at level 3
    set_ctl(2, 1, 0, 1, 0, 1);
    priv_lvl = 2'd2;
    pulse('0, 1'b1);
    exp_cnt(N, 2, "R6");
    priv_lvl = 2'd3;
    pulse('0, 1'b1);
    exp_cnt(N, 3, "R6");
    set_ctl(2, 1, 0, 0, 1, 0);
    priv_lvl = 2'd2;
    pulse('1, 1'b1);
    exp_cnt(N, 3, "R6"); exp_evt4(6, 5, 5, 4, "R6");
    priv_lvl = 2'd0;
    pulse('0, 1'b1);
    exp_cnt(N, 4, "R6");

    // R2 split 0 and split above N act as N
    set_ctl(0, 0, 0, 0, 0, 0);
    priv_lvl = 2'd1;
    pulse('1, 1'b0);
    exp_evt4(7, 6, 6, 5, "R2");
    set_ctl(7, 0, 0, 1, 0, 0);
    priv_lvl = 2'd2;
    pulse('1, 1'b0);
    exp_evt4(7, 6, 6, 5, "R2");

    // R12 long bit ignored when split is N
    priv_lvl = 2'd1;
    set_ctl(4, 0, 1, 0, 0, 0);
    clear_all("R8");
    wr_cnt(3, 64'h0000_0000_FFFF_FFFF);
    pulse(4'b1000, 1'b0);
    exp_cnt(3, 64'h1_0000_0000, "R12"); exp_ovf(5'b01000, "R12");

    // R7 overflow widths
    clear_all("R8");
    set_ctl(2, 1, 0, 0, 0, 0);
    wr_cnt(2, 64'h0000_0000_FFFF_FFFF);
    pulse(4'b0100, 1'b0);
    exp_cnt(2, 64'h1_0000_0000, "R7"); exp_ovf(5'b00100, "R7");
    clear_all("R8");
    set_ctl(2, 1, 1, 0, 0, 0);
    wr_cnt(2, 64'h0000_0001_FFFF_FFFF);
    pulse(4'b0100, 1'b0);
    exp_cnt(2, 64'h2_0000_0000, "R7"); exp_ovf('0, "R7");
    wr_cnt(2, '1);
    pulse(4'b0100, 1'b0);
    exp_cnt(2, 0, "R7"); exp_ovf(5'b00100, "R7");
    wr_cnt(0, 64'h0000_0005_FFFF_FFFF);
    pulse(4'b0001, 1'b0);
    exp_cnt(0, 64'h6_0000_0000, "R7"); exp_ovf(5'b00101, "R7");
    wr_cnt(N, 64'h0000_0000_FFFF_FFFF);
    pulse('0, 1'b1);
    exp_cnt(N, 64'h1_0000_0000, "R7"); exp_ovf(5'b00101, "R7");
    wr_cnt(N, '1);
    pulse('0, 1'b1);
    exp_cnt(N, 0, "R7"); exp_ovf(5'b10101, "R7");

    // R8 sticky, selective clear, set beats clear
    prep(); step();
    exp_ovf(5'b10101, "R8");
    prep(); ovf_clr = 5'b00100; step();
    exp_ovf(5'b10001, "R8");
    wr_cnt(1, 64'h0000_0000_FFFF_FFFF);
    prep(); evt = 4'b0010; ovf_clr = 5'b00010; step();
    exp_ovf(5'b10011, "R8");
    clear_all("R8");

    // R9 write priority, cycle index, no overflow from writes, bad index
    prep(); wr_en = 1'b1; wr_idx = 1; wr_data = 64'd100; evt = 4'b0010; step();
    exp_cnt(1, 100, "R9");
    prep(); wr_en = 1'b1; wr_idx = IW'(N); wr_data = 64'd50; tick = 1'b1; step();
    exp_cnt(N, 50, "R9");
    prep(); wr_en = 1'b1; wr_idx = 0; wr_data = 64'h0000_0000_FFFF_FFFF; evt = 4'b0001; step();
    exp_cnt(0, 64'h0000_0000_FFFF_FFFF, "R9"); exp_ovf('0, "R9");
    wr_cnt(5, 64'd9);
    exp_cnt(0, 64'h0000_0000_FFFF_FFFF, "R9"); exp_cnt(1, 100, "R9"); exp_cnt(N, 50, "R9");

    // R10 read port
    prep(); rd_idx = 1; step();
    exp_rd(100, "R10");
    prep(); rd_idx = IW'(N); step();
    exp_rd(50, "R10");
    prep(); rd_idx = 6; step();
    exp_rd(0, "R10");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule